// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry-Out

This block shifts or rotates a 32-bit word by a distance read from the low byte of a second 32-bit operand. It also produces the carry bit that such a shift yields. Four operations are chosen by a 2-bit select: logical left, logical right, arithmetic right and rotate right. The current carry flag comes in beside the data. The block passes that flag through whenever the effective distance is zero.

Distances from 1 to 31 behave like an ordinary barrel shift. Distances of 32 and above, and a distance of zero, follow separate rules for each operation. Those rules are listed below. The datapath is combinational. By default an output register captures the result and carry on each cycle that the valid strobe is high, and otherwise holds them.

Top module: `shift_carry_unit`

## Requirements
- R1: Only bits [7:0] of `amount_in` form the distance; bits [31:8] have no effect on the result or on the carry.
- R2: A zero distance returns `data_in` unchanged and gives `carry_in` as the carry, for every operation.
- R3: With select 00 (logical left): distance d in 1..31 gives `data_in << d` and carry `data_in[32-d]`. Distance 32 gives 0 with carry `data_in[0]`. Distance above 32 gives 0 with carry 0.
- R4: With select 01 (logical right): distance d in 1..31 gives `data_in >> d` and carry `data_in[d-1]`. Distance 32 gives 0 with carry `data_in[31]`. Distance above 32 gives 0 with carry 0.
- R5: With select 10 (arithmetic right): distance d in 1..31 shifts in copies of bit 31 and gives carry `data_in[d-1]`. Distance 32 or more gives every bit equal to `data_in[31]`, and the carry equal to `data_in[31]`.
- R6: With select 11 (rotate right): the rotation is the distance modulo 32. When that rotation r is non-zero, the result is `data_in` rotated right by r and the carry is `data_in[r-1]`.
- R7: With select 11, a non-zero distance that is a multiple of 32 returns `data_in` unchanged and gives carry `data_in[31]`.
- R8: On a clock edge where `in_valid` is high, `result_out` and `carry_out` take the computed values, and `out_valid` is high in the following cycle; `out_valid` is low after an edge where `in_valid` was low.
- R9: On an edge where `in_valid` is low, `result_out` and `carry_out` keep their values whatever the other inputs do.
- R10: While `rst` is high, `result_out`, `carry_out` and `out_valid` are cleared to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the output register |
| op_sel | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| data_in | input | 32 | Word to shift |
| amount_in | input | 32 | Distance operand; low byte used |
| carry_in | input | 1 | Current carry flag |
| result_out | output | 32 | Registered shift result |
| carry_out | output | 1 | Registered new carry flag |
| out_valid | output | 1 | High the cycle after a capture |

## Verification
Two functions can meet in the same cycle: a zero-distance pass-through and the capture strobe. In that cycle the register must load the incoming `carry_in`, not keep its old carry. The bench provokes this by first capturing a result whose carry is the opposite value. It then strobes a zero-distance vector with a carry that differs from the stored one, including a case where the non-zero upper bits of the operand mask a zero low byte. The captured carry is compared with the new input flag, and the stored value is treated as wrong.

// File: rtl/shc_pkg.sv
package shc_pkg;

    // Operation select; the encoding is visible on the op_sel port.
    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_LSR = 2'b01,
        OP_ASR = 2'b10,
        OP_ROR = 2'b11
    } shc_op_e;

    // Range class of the effective distance relative to the word width.
    typedef struct packed {
        logic zero;    // distance is 0
        logic below;   // 1 .. WIDTH-1
        logic exact;   // exactly WIDTH
        logic beyond;  // greater than WIDTH
        logic rot_nil; // distance modulo WIDTH is 0
    } amt_class_t;

    // Result word plus carry, carried between stages.
    typedef struct packed {
        logic [31:0] word;
        logic        carry;
    } shc_res_t;

endpackage

// File: rtl/shc_amount_decode.sv
module shc_amount_decode
    import shc_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [AMT_BITS-1:0] amt,
    output amt_class_t          cls,
    output logic [SH_BITS-1:0]  sh
);

    localparam logic [AMT_BITS-1:0] W_AMT = AMT_BITS'(WIDTH);

    always_comb begin
        cls.zero    = (amt == '0);
        cls.exact   = (amt == W_AMT);
        cls.beyond  = (amt > W_AMT);
        cls.below   = !cls.zero && (amt < W_AMT);
        cls.rot_nil = (amt[SH_BITS-1:0] == '0);
        sh          = amt[SH_BITS-1:0];
    end

endmodule

// File: rtl/shc_core.sv
module shc_core
    import shc_pkg::*;
#(
    parameter int WIDTH    = 32,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [1:0]         op_sel,
    input  logic [WIDTH-1:0]   data,
    input  logic               cin,
    input  amt_class_t         cls,
    input  logic [SH_BITS-1:0] sh,
    output logic [WIDTH-1:0]   res,
    output logic               cout
);

    shc_op_e                   op;
    logic signed [WIDTH-1:0]   sdata;
    logic [2*WIDTH-1:0]        dbl;
    logic [SH_BITS-1:0]        left_idx;
    logic [SH_BITS-1:0]        right_idx;
    logic                      msb;

    always_comb begin
        op        = shc_op_e'(op_sel);
        sdata     = data;
        dbl       = {data, data} >> sh;
        // WIDTH is a power of two, so WIDTH - sh wraps to -sh.
        left_idx  = -sh;
        right_idx = sh - 1'b1;
        msb       = data[WIDTH-1];

        res  = data;
        cout = cin;
        if (!cls.zero) begin
            unique case (op)
                OP_LSL: begin
                    if (cls.below) begin
                        res  = data << sh;
                        cout = data[left_idx];
                    end else begin
                        res  = '0;
                        cout = cls.exact ? data[0] : 1'b0;
                    end
                end
                OP_LSR: begin
                    if (cls.below) begin
                        res  = data >> sh;
                        cout = data[right_idx];
                    end else begin
                        res  = '0;
                        cout = cls.exact ? msb : 1'b0;
                    end
                end
                OP_ASR: begin
                    if (cls.below) begin
                        res  = sdata >>> sh;
                        cout = data[right_idx];
                    end else begin
                        res  = {WIDTH{msb}};
                        cout = msb;
                    end
                end
                OP_ROR: begin
                    if (cls.rot_nil) begin
                        res  = data;
                        cout = msb;
                    end else begin
                        res  = dbl[WIDTH-1:0];
                        cout = data[right_idx];
                    end
                end
                default: begin
                    res  = data;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/shc_out_stage.sv
module shc_out_stage #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] res,
    input  logic             cout,
    output logic [WIDTH-1:0] result_q,
    output logic             carry_q,
    output logic             valid_q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    result_q <= '0;
                    carry_q  <= 1'b0;
                    valid_q  <= 1'b0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid) begin
                        result_q <= res;
                        carry_q  <= cout;
                    end
                end
            end
        end else begin : g_comb
            assign result_q = res;
            assign carry_q  = cout;
            assign valid_q  = in_valid;
        end
    endgenerate

endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
    import shc_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] amount_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result_out,
    output logic             carry_out,
    output logic             out_valid
);

    localparam int SH_BITS = $clog2(WIDTH);

    amt_class_t         cls;
    logic [SH_BITS-1:0] sh;
    logic [WIDTH-1:0]   core_res;
    logic               core_cout;
    logic               unused_amt_hi;

    // Upper operand bits are deliberately dropped.
    assign unused_amt_hi = ^amount_in[WIDTH-1:AMT_BITS];

    shc_amount_decode #(
        .WIDTH    (WIDTH),
        .AMT_BITS (AMT_BITS)
    ) u_decode (
        .amt (amount_in[AMT_BITS-1:0]),
        .cls (cls),
        .sh  (sh)
    );

    shc_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .op_sel (op_sel),
        .data   (data_in),
        .cin    (carry_in),
        .cls    (cls),
        .sh     (sh),
        .res    (core_res),
        .cout   (core_cout)
    );

    shc_out_stage #(
        .WIDTH   (WIDTH),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .res      (core_res),
        .cout     (core_cout),
        .result_q (result_out),
        .carry_q  (carry_out),
        .valid_q  (out_valid)
    );

endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] data_in,
    input logic [WIDTH-1:0] amount_in,
    input logic             carry_in,
    input logic [WIDTH-1:0] result_out,
    input logic             carry_out,
    input logic             out_valid
);

    localparam int SH_BITS = $clog2(WIDTH);
    localparam logic [AMT_BITS-1:0] W_AMT = AMT_BITS'(WIDTH);

    logic [AMT_BITS-1:0] amt_lo;
    logic                unused_chk_hi;
    assign amt_lo        = amount_in[AMT_BITS-1:0];
    assign unused_chk_hi = ^amount_in[WIDTH-1:AMT_BITS];

    generate
        if (REG_OUT) begin : g_props
            // R2
            p_zero_pass_r2: assert property (@(posedge clk) disable iff (rst)
                (in_valid && amt_lo == '0) |=>
                    (result_out == $past(data_in) && carry_out == $past(carry_in)));
            // R3
            p_lsl_beyond_r3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 2'b00 && amt_lo > W_AMT) |=>
                    (result_out == '0 && !carry_out));
            // R4
            p_lsr_exact_r4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 2'b01 && amt_lo == W_AMT) |=>
                    (result_out == '0 && carry_out == $past(data_in[WIDTH-1])));
            // R5
            p_asr_fill_r5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 2'b10 && amt_lo >= W_AMT) |=>
                    (result_out == {WIDTH{$past(data_in[WIDTH-1])}} &&
                     carry_out == $past(data_in[WIDTH-1])));
            // R7
            p_ror_whole_r7: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 2'b11 && amt_lo != '0 &&
                 amt_lo[SH_BITS-1:0] == '0) |=>
                    (result_out == $past(data_in) && carry_out == $past(data_in[WIDTH-1])));
            // R8
            p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R9
            p_hold_r9: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(result_out) && $stable(carry_out)));
        end
    endgenerate

endmodule

bind shift_carry_unit shc_checker #(
    .WIDTH    (WIDTH),
    .AMT_BITS (AMT_BITS),
    .REG_OUT  (REG_OUT)
) u_shc_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .data_in    (data_in),
    .amount_in  (amount_in),
    .carry_in   (carry_in),
    .result_out (result_out),
    .carry_out  (carry_out),
    .out_valid  (out_valid)
);

// File: tb/test_shift_carry_unit.sv
module test_shift_carry_unit;

    localparam time CLK_HALF = 5ns;
    localparam int  NVEC     = 19;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] data;
        logic [31:0] amt;
        logic        cin;
        logic [31:0] res;
        logic        cout;
        logic [7:0]  req;
    } vec_t;

    // Word used in most rows: 0xB40000C3
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'hB40000C3, 32'd4,          1'b0, 32'h40000C30, 1'b1, 8'd3}, // R3 small
        '{2'b00, 32'hB40000C3, 32'd32,         1'b0, 32'h00000000, 1'b1, 8'd3}, // R3 exact
        '{2'b00, 32'hB40000C3, 32'd33,         1'b1, 32'h00000000, 1'b0, 8'd3}, // R3 beyond
        '{2'b00, 32'h00000003, 32'd31,         1'b0, 32'h80000000, 1'b1, 8'd3}, // R3 max small
        '{2'b01, 32'hB40000C3, 32'd1,          1'b0, 32'h5A000061, 1'b1, 8'd4}, // R4 small
        '{2'b01, 32'hB40000C3, 32'd31,         1'b1, 32'h00000001, 1'b0, 8'd4}, // R4 max small
        '{2'b01, 32'hB40000C3, 32'd32,         1'b0, 32'h00000000, 1'b1, 8'd4}, // R4 exact
        '{2'b01, 32'hB40000C3, 32'd200,        1'b1, 32'h00000000, 1'b0, 8'd4}, // R4 beyond
        '{2'b10, 32'hB40000C3, 32'd8,          1'b0, 32'hFFB40000, 1'b1, 8'd5}, // R5 small
        '{2'b10, 32'hB40000C3, 32'd40,         1'b0, 32'hFFFFFFFF, 1'b1, 8'd5}, // R5 beyond
        '{2'b10, 32'h70000000, 32'd255,        1'b1, 32'h00000000, 1'b0, 8'd5}, // R5 positive
        '{2'b11, 32'hB40000C3, 32'd8,          1'b0, 32'hC3B40000, 1'b1, 8'd6}, // R6
        '{2'b11, 32'hB40000C3, 32'd36,         1'b1, 32'h3B40000C, 1'b0, 8'd6}, // R6 modulo
        '{2'b11, 32'hB40000C3, 32'd64,         1'b0, 32'hB40000C3, 1'b1, 8'd7}, // R7
        '{2'b11, 32'h00000001, 32'd32,         1'b1, 32'h00000001, 1'b0, 8'd7}, // R7
        '{2'b00, 32'hB40000C3, 32'd0,          1'b1, 32'hB40000C3, 1'b1, 8'd2}, // R2
        '{2'b10, 32'hB40000C3, 32'd0,          1'b0, 32'hB40000C3, 1'b0, 8'd2}, // R2
        '{2'b11, 32'hB40000C3, 32'hFFFFFF00,   1'b1, 32'hB40000C3, 1'b1, 8'd1}, // R1 zero byte
        '{2'b01, 32'hB40000C3, 32'h12345601,   1'b0, 32'h5A000061, 1'b1, 8'd1}  // R1 byte 1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] data_in = '0;
    logic [31:0] amount_in = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result_out;
    logic        carry_out;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #CLK_HALF clk = ~clk;

    shift_carry_unit i_shift_carry_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .data_in    (data_in),
        .amount_in  (amount_in),
        .carry_in   (carry_in),
        .result_out (result_out),
        .carry_out  (carry_out),
        .out_valid  (out_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] d,
                         input logic [31:0] a, input logic c);
        @(negedge clk);
        in_valid  = v;
        op_sel    = op;
        data_in   = d;
        amount_in = a;
        carry_in  = c;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 result after reset", result_out, 32'h0);
        chk("R10 carry after reset", {31'h0, carry_out}, 32'h0);
        chk("R10 valid after reset", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;

        // Table walk: drive at a falling edge, capture at the rising edge, read next falling edge.
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].data, VECS[i].amt, VECS[i].cin);
            @(negedge clk);
            chk($sformatf("R%0d row %0d result", VECS[i].req, i), result_out, VECS[i].res);
            chk($sformatf("R%0d row %0d carry", VECS[i].req, i), {31'h0, carry_out}, {31'h0, VECS[i].cout});
            chk($sformatf("R8 row %0d valid", i), {31'h0, out_valid}, 32'h1);
        end

        // R2 with capture: stored carry 0, then zero distance with carry_in 1 (upper bits set, R1)
        drive(1'b1, 2'b00, 32'h00000001, 32'd33, 1'b1);
        @(negedge clk);
        chk("R3 setup carry", {31'h0, carry_out}, 32'h0);
        drive(1'b1, 2'b01, 32'h0F0F0F0F, 32'hABCDEF00, 1'b1);
        @(negedge clk);
        chk("R2 captured carry_in", {31'h0, carry_out}, 32'h1);
        chk("R1 R2 captured data", result_out, 32'h0F0F0F0F);

        // R9: strobe low, inputs change, outputs hold
        drive(1'b0, 2'b00, 32'hFFFFFFFF, 32'd1, 1'b0);
        @(negedge clk);
        chk("R8 valid low after idle", {31'h0, out_valid}, 32'h0);
        drive(1'b0, 2'b10, 32'h80000000, 32'd50, 1'b0);
        @(negedge clk);
        chk("R9 result held", result_out, 32'h0F0F0F0F);
        chk("R9 carry held", {31'h0, carry_out}, 32'h1);

        // R8: single strobe, one-cycle latency
        drive(1'b1, 2'b11, 32'h00000010, 32'd4, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 result after strobe", result_out, 32'h00000001);
        chk("R8 valid after strobe", {31'h0, out_valid}, 32'h1);

        // R10: reset mid-run clears
        rst = 1'b1;
        @(negedge clk);
        chk("R10 result on reset", result_out, 32'h0);
        chk("R10 valid on reset", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule